// File: doc/BRIEF.md
# Directory Sharer Vector with Overflow

This block keeps the sharer-tracking field of a single coherence directory entry. The field can take one of three forms. The owner form points at one exclusive holder and names a processor, not a node. The shared form is a precise vector with one bit per node. The coarse form gives one bit to each fixed group of nodes. Each node contains two processors. The protocol controller drives one command at a time: add a sharer, make a processor the exclusive owner, clear the entry, or fan out invalidations. A mode input can force coarse tracking.

The entry picks its own form as it runs. A sharer whose node lies outside the precise vector's range switches the entry to the coarse form, and any precise bits already held are folded into their group bits. An invalidate command takes a snapshot of the current holders, expanded to node granularity, and removes the requesting processor's node from it. The sequencer then emits one node index per handshake, lowest node first. A node index stands for both processors in that node. When the list is exhausted the sequencer raises a done strobe together with the number of invalidations it issued. Commands are refused while a fan-out is in progress.

Top module: `dsv_sharer_entry`

## Requirements
- R1: After synchronous reset the entry is in shared format (code 0) with an all-zero vector and a zero owner field, `cmd_ready` is 1, and neither `inv_valid` nor `inv_done` is asserted.
- R2: An accepted owner command (op code 1) sets format code 1 and stores the full processor id in `ent_owner`, with the vector cleared. The node of processor p is p/2.
- R3: An add-sharer command (op code 0) for node n < 16, with `force_coarse` low and the entry in shared format, sets vector bit n and keeps the bits already set.
- R4: An add-sharer command from shared format whose node is 16 or above, or that arrives with `force_coarse` high, switches the entry to coarse format (code 2). Each set precise bit i is folded into group bit i/4, and group bit n/4 is set as well.
- R5: An add-sharer command in owner format converts the entry to a sharer vector that holds both the old owner's node and the new node. The result is shared format if both nodes are below 16 and coarse mode is not forced, and coarse format otherwise. The owner field returns to zero.
- R6: An add-sharer command in coarse format sets group bit n/4 and leaves the format coarse.
- R7: An accepted clear command (op code 2) returns the entry to shared format with an empty vector and a zero owner field.
- R8: After an invalidate command (op code 3), target nodes appear on `inv_node` in strictly ascending order, one per cycle in which `inv_valid` and `inv_ready` are both high. While `inv_ready` is low, the presented node stays the same.
- R9: In coarse format, the invalidation targets are all four nodes of every group whose bit is set, including nodes that never held a copy. In shared format they are the set bits. In owner format the target is the owner's node.
- R10: The node of the processor carried with the invalidate command is never issued as a target.
- R11: When every target has been issued, `inv_done` pulses for one cycle with `inv_count` equal to the number of targets. With no targets, the pulse comes in the first cycle after the command is accepted.
- R12: While a fan-out is in progress, `cmd_ready` is low and any command presented is ignored, so the entry seen after `inv_done` is unchanged. The entry itself is not altered by an invalidate command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 add sharer, 1 set owner, 2 clear, 3 invalidate |
| cmd_proc | input | 7 | Processor id (sharer, owner or requestor) |
| force_coarse | input | 1 | Selects coarse tracking on the next sharer add |
| cmd_ready | output | 1 | Command accepted when high |
| ent_fmt | output | 2 | Current format: 0 shared, 1 owner, 2 coarse |
| ent_vec | output | 16 | Precise or coarse sharer vector |
| ent_owner | output | 7 | Owner processor id in owner format |
| inv_valid | output | 1 | Invalidation target presented |
| inv_ready | input | 1 | Target accepted by the network side |
| inv_node | output | 6 | Target node index |
| inv_done | output | 1 | One-cycle end-of-fan-out strobe |
| inv_count | output | 7 | Number of targets issued, valid with inv_done |

## Verification
The bench builds the block with its default sizing: 64 nodes of two processors each, a 16-bit vector and groups of four nodes. With this sizing a node id above 15 reaches the overflow path, and a single coarse bit fans out to four targets. A fully set coarse vector produces 63 targets, which exercises the widest count. Stalls on `inv_ready` are drawn at random, so the hold behaviour, the requestor exclusion and commands refused while busy are all exercised in many different cycles of the fan-out.

// File: rtl/dsv_pkg.sv
package dsv_pkg;

    localparam int unsigned NODES          = 64;
    localparam int unsigned PROCS_PER_NODE = 2;
    localparam int unsigned VEC_BITS       = 16;
    localparam int unsigned GROUP          = NODES / VEC_BITS;
    localparam int unsigned NODE_W         = $clog2(NODES);
    localparam int unsigned PROC_W         = $clog2(NODES * PROCS_PER_NODE);
    localparam int unsigned CNT_W          = $clog2(NODES + 1);

    typedef enum logic [1:0] {
        FMT_SHARED = 2'd0,
        FMT_OWNER  = 2'd1,
        FMT_COARSE = 2'd2
    } fmt_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_OWN = 2'd1,
        OP_CLR = 2'd2,
        OP_INV = 2'd3
    } op_e;

    typedef logic [NODE_W-1:0]   node_t;
    typedef logic [PROC_W-1:0]   proc_t;
    typedef logic [VEC_BITS-1:0] vec_t;
    typedef logic [NODES-1:0]    mask_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef struct packed {
        fmt_e  fmt;
        vec_t  vec;
        proc_t owner;
    } entry_t;

    // node that houses a processor
    function automatic node_t node_of(proc_t p);
        return node_t'(int'(p) / PROCS_PER_NODE);
    endfunction

    // coarse bit covering a node
    function automatic vec_t grp_bit(node_t n);
        return vec_t'(1) << (int'(n) / GROUP);
    endfunction

    // precise vector folded into coarse group bits
    function automatic vec_t fold(vec_t v);
        vec_t r = '0;
        for (int i = 0; i < VEC_BITS; i++) begin
            if (v[i]) r = r | grp_bit(node_t'(i));
        end
        return r;
    endfunction

    // lowest set node of a mask
    function automatic node_t first_set(mask_t m);
        node_t r = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (m[i]) r = node_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/dsv_entry_reg.sv
module dsv_entry_reg
    import dsv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   upd_en,
    input  op_e    op,
    input  proc_t  proc,
    input  logic   force_coarse,
    output entry_t ent
);

    node_t  new_node;
    node_t  own_node;
    logic   want_coarse;
    vec_t   prec_base;
    vec_t   crs_base;
    entry_t nxt;

    assign new_node = node_of(proc);
    assign own_node = node_of(ent.owner);

    // overflow decision: forced, new node out of range, or old owner out of range
    assign want_coarse = force_coarse
                       || (int'(new_node) >= VEC_BITS)
                       || (ent.fmt == FMT_OWNER && int'(own_node) >= VEC_BITS);

    assign prec_base = (ent.fmt == FMT_SHARED) ? ent.vec : (vec_t'(1) << own_node);
    assign crs_base  = (ent.fmt == FMT_SHARED) ? fold(ent.vec) : grp_bit(own_node);

    always_comb begin
        nxt = ent;
        case (op)
            OP_CLR: begin
                nxt.fmt   = FMT_SHARED;
                nxt.vec   = '0;
                nxt.owner = '0;
            end
            OP_OWN: begin
                nxt.fmt   = FMT_OWNER;
                nxt.vec   = '0;
                nxt.owner = proc;
            end
            OP_ADD: begin
                nxt.owner = '0;
                if (ent.fmt == FMT_COARSE) begin
                    nxt.vec = ent.vec | grp_bit(new_node);
                end else if (!want_coarse) begin
                    nxt.fmt = FMT_SHARED;
                    nxt.vec = prec_base | (vec_t'(1) << new_node);
                end else begin
                    nxt.fmt = FMT_COARSE;
                    nxt.vec = crs_base | grp_bit(new_node);
                end
            end
            OP_INV: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '{fmt: FMT_SHARED, vec: '0, owner: '0};
        end else if (upd_en) begin
            ent <= nxt;
        end
    end

endmodule

// File: rtl/dsv_expand.sv
module dsv_expand
    import dsv_pkg::*;
(
    input  entry_t ent,
    output mask_t  targets
);

    node_t own_node;
    mask_t prec;

    assign own_node = node_of(ent.owner);

    for (genvar i = 0; i < NODES; i++) begin : g_node
        if (i < VEC_BITS) begin : g_in
            assign prec[i] = ent.vec[i];
        end else begin : g_out
            assign prec[i] = 1'b0;
        end

        always_comb begin
            case (ent.fmt)
                FMT_COARSE: targets[i] = ent.vec[i / GROUP];
                FMT_OWNER:  targets[i] = (own_node == node_t'(i));
                default:    targets[i] = prec[i];
            endcase
        end
    end

endmodule

// File: rtl/dsv_inval_seq.sv
module dsv_inval_seq
    import dsv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  mask_t targets,
    input  node_t req_node,
    input  logic  inv_ready,
    output logic  busy,
    output logic  inv_valid,
    output node_t inv_node,
    output logic  done,
    output cnt_t  done_count,
    output node_t req_q
);

    mask_t pending;
    cnt_t  issued;
    logic  empty;

    assign empty      = (pending == '0);
    assign inv_valid  = busy && !empty;
    assign inv_node   = first_set(pending);
    assign done       = busy && empty;
    assign done_count = issued;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            pending <= '0;
            issued  <= '0;
            req_q   <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            pending <= targets & ~(mask_t'(1) << req_node);
            issued  <= '0;
            req_q   <= req_node;
        end else if (busy) begin
            if (empty) begin
                busy <= 1'b0;
            end else if (inv_ready) begin
                pending <= pending & ~(mask_t'(1) << inv_node);
                issued  <= issued + cnt_t'(1);
            end
        end
    end

endmodule

// File: rtl/dsv_sharer_entry.sv
module dsv_sharer_entry
    import dsv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [PROC_W-1:0]   cmd_proc,
    input  logic                force_coarse,
    output logic                cmd_ready,
    output logic [1:0]          ent_fmt,
    output logic [VEC_BITS-1:0] ent_vec,
    output logic [PROC_W-1:0]   ent_owner,
    output logic                inv_valid,
    input  logic                inv_ready,
    output logic [NODE_W-1:0]   inv_node,
    output logic                inv_done,
    output logic [CNT_W-1:0]    inv_count
);

    entry_t ent;
    mask_t  targets;
    logic   busy;
    logic   accept;
    op_e    op;
    node_t  req_q;

    assign op        = op_e'(cmd_op);
    assign cmd_ready = !busy;
    assign accept    = cmd_valid && cmd_ready;

    dsv_entry_reg u_entry (
        .clk          (clk),
        .rst          (rst),
        .upd_en       (accept && op != OP_INV),
        .op           (op),
        .proc         (cmd_proc),
        .force_coarse (force_coarse),
        .ent          (ent)
    );

    dsv_expand u_expand (
        .ent     (ent),
        .targets (targets)
    );

    dsv_inval_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (accept && op == OP_INV),
        .targets    (targets),
        .req_node   (node_of(cmd_proc)),
        .inv_ready  (inv_ready),
        .busy       (busy),
        .inv_valid  (inv_valid),
        .inv_node   (inv_node),
        .done       (inv_done),
        .done_count (inv_count),
        .req_q      (req_q)
    );

    assign ent_fmt   = ent.fmt;
    assign ent_vec   = ent.vec;
    assign ent_owner = ent.owner;

endmodule

// File: rtl/dsv_sharer_entry_chk.sv
module dsv_sharer_entry_chk
    import dsv_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic [1:0]          cmd_op,
    input logic [PROC_W-1:0]   cmd_proc,
    input logic                cmd_ready,
    input logic [1:0]          ent_fmt,
    input logic [VEC_BITS-1:0] ent_vec,
    input logic [PROC_W-1:0]   ent_owner,
    input logic                inv_valid,
    input logic                inv_ready,
    input logic [NODE_W-1:0]   inv_node,
    input logic                inv_done,
    input logic [NODE_W-1:0]   req_node
);

    assert_owner_load_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_op == OP_OWN
        |=> ent_fmt == FMT_OWNER && ent_owner == $past(cmd_proc));

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready && cmd_op == OP_CLR
        |=> ent_fmt == FMT_SHARED && ent_vec == '0 && ent_owner == '0);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        inv_valid && !inv_ready |=> inv_valid && $stable(inv_node));

    assert_ascend_R8: assert property (@(posedge clk) disable iff (rst)
        inv_valid && inv_ready |=> !inv_valid || inv_node > $past(inv_node));

    assert_coarse_cover_R9: assert property (@(posedge clk) disable iff (rst)
        inv_valid && ent_fmt == FMT_COARSE |-> |(ent_vec & grp_bit(inv_node)));

    assert_shared_cover_R9: assert property (@(posedge clk) disable iff (rst)
        inv_valid && ent_fmt == FMT_SHARED |-> |(ent_vec & (vec_t'(1) << inv_node)));

    assert_no_self_R10: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> inv_node != req_node);

    assert_done_release_R11: assert property (@(posedge clk) disable iff (rst)
        inv_done |=> cmd_ready && !inv_valid && !inv_done);

    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready
        |=> $stable(ent_fmt) && $stable(ent_vec) && $stable(ent_owner));

endmodule

bind dsv_sharer_entry dsv_sharer_entry_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_proc  (cmd_proc),
    .cmd_ready (cmd_ready),
    .ent_fmt   (ent_fmt),
    .ent_vec   (ent_vec),
    .ent_owner (ent_owner),
    .inv_valid (inv_valid),
    .inv_ready (inv_ready),
    .inv_node  (inv_node),
    .inv_done  (inv_done),
    .req_node  (req_q)
);

// File: tb/test_dsv_sharer_entry.sv
module test_dsv_sharer_entry;

    localparam int F_SH = 0, F_OW = 1, F_CO = 2;
    localparam int O_ADD = 0, O_OWN = 1, O_CLR = 2, O_INV = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [6:0]  cmd_proc;
    logic        force_coarse;
    logic        cmd_ready;
    logic [1:0]  ent_fmt;
    logic [15:0] ent_vec;
    logic [6:0]  ent_owner;
    logic        inv_valid;
    logic        inv_ready;
    logic [5:0]  inv_node;
    logic        inv_done;
    logic [6:0]  inv_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          m_fmt;
    logic [15:0] m_vec;
    logic [6:0]  m_owner;

    always #10 clk = ~clk;

    dsv_sharer_entry i_dsv_sharer_entry (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_proc(cmd_proc), .force_coarse(force_coarse), .cmd_ready(cmd_ready),
        .ent_fmt(ent_fmt), .ent_vec(ent_vec), .ent_owner(ent_owner),
        .inv_valid(inv_valid), .inv_ready(inv_ready), .inv_node(inv_node),
        .inv_done(inv_done), .inv_count(inv_count)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_entry(string req);
        check(ent_fmt == 2'(m_fmt), req, ent_fmt, m_fmt);
        check(ent_vec == m_vec, req, ent_vec, m_vec);
        check(ent_owner == m_owner, req, ent_owner, m_owner);
    endtask

    function automatic logic [15:0] gbit(int n);
        return 16'(1) << (n / 4);
    endfunction

    function automatic logic [63:0] exp_targets();
        logic [63:0] t = '0;
        for (int i = 0; i < 64; i++) begin
            if (m_fmt == F_CO) t[i] = m_vec[i / 4];
            else if (m_fmt == F_OW) t[i] = (int'(m_owner) / 2 == i);
            else if (i < 16) t[i] = m_vec[i];
        end
        return t;
    endfunction

    task automatic model_update(int op, int proc, bit frc);
        int n = proc / 2;
        int on = int'(m_owner) / 2;
        logic [15:0] cv;
        case (op)
            O_CLR: begin m_fmt = F_SH; m_vec = '0; m_owner = '0; end
            O_OWN: begin m_fmt = F_OW; m_vec = '0; m_owner = 7'(proc); end
            O_ADD: begin
                if (m_fmt == F_CO) begin
                    m_vec = m_vec | gbit(n);
                end else if (!frc && n < 16 && !(m_fmt == F_OW && on >= 16)) begin
                    m_vec = ((m_fmt == F_SH) ? m_vec : (16'(1) << on)) | (16'(1) << n);
                    m_fmt = F_SH;
                end else begin
                    cv = '0;
                    if (m_fmt == F_SH) begin
                        for (int i = 0; i < 16; i++) if (m_vec[i]) cv = cv | gbit(i);
                    end else cv = gbit(on);
                    m_vec = cv | gbit(n);
                    m_fmt = F_CO;
                end
                m_owner = '0;
            end
            default: ;
        endcase
    endtask

    task automatic run_inval(int req);
        logic [63:0] t = exp_targets();
        int list[64];
        int n_exp = 0;
        int idx = 0;
        bit rdy;
        t[req] = 1'b0;
        for (int i = 0; i < 64; i++) if (t[i]) begin list[n_exp] = i; n_exp++; end
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (inv_done) begin
                check(inv_count == 7'(n_exp), "R11 count", inv_count, n_exp);
                check(idx == n_exp, "R11 all issued", idx, n_exp);
                break;
            end
            check(inv_valid, "R8 valid while pending", inv_valid, 1);
            if (idx < n_exp) check(inv_node == 6'(list[idx]), "R9 R10 target", inv_node, list[idx]);
            else check(0, "R8 extra target", inv_node, -1);
            check(!cmd_ready, "R12 busy", cmd_ready, 0);
            rdy = ($urandom % 3) != 0;
            if (rdy) idx++;
            inv_ready = rdy;
            if (($urandom % 4) == 0) begin
                cmd_valid = 1'b1;
                cmd_op = 2'($urandom % 3);
                cmd_proc = 7'($urandom);
            end
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        inv_ready = 1'b0;
        @(negedge clk);
        check(cmd_ready && !inv_valid && !inv_done, "R11 release", {cmd_ready, inv_valid, inv_done}, 4);
        check_entry("R12 entry unchanged");
    endtask

    task automatic do_cmd(int op, int proc, bit frc, string req);
        @(negedge clk);
        check(cmd_ready, "R12 ready when idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_proc = 7'(proc); force_coarse = frc;
        @(negedge clk);
        cmd_valid = 1'b0; force_coarse = 1'b0;
        if (op == O_INV) run_inval(proc / 2);
        else begin
            model_update(op, proc, frc);
            check_entry(req);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_proc = '0;
        force_coarse = 1'b0; inv_ready = 1'b0;
        m_fmt = F_SH; m_vec = '0; m_owner = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_entry("R1");
        check(cmd_ready && !inv_valid && !inv_done, "R1 handshake", {cmd_ready, inv_valid, inv_done}, 4);

        // R3 precise adds, R10 requestor node 7 excluded
        do_cmd(O_ADD, 6, 0, "R3");
        do_cmd(O_ADD, 15, 0, "R3");
        do_cmd(O_ADD, 31, 0, "R3");
        do_cmd(O_INV, 14, 0, "R10");
        // R4 overflow by node 20, then R9 coarse fan-out
        do_cmd(O_ADD, 41, 0, "R4");
        do_cmd(O_INV, 10, 0, "R9");
        // R6 coarse add
        do_cmd(O_ADD, 127, 0, "R6");
        // R2 owner, R11 zero-target fan-out
        do_cmd(O_OWN, 9, 0, "R2");
        do_cmd(O_INV, 8, 0, "R11");
        do_cmd(O_INV, 0, 0, "R9 owner");
        // R5 owner to shared and owner to coarse
        do_cmd(O_ADD, 20, 0, "R5");
        do_cmd(O_OWN, 41, 0, "R2");
        do_cmd(O_ADD, 4, 0, "R5");
        // R7 clear, R4 forced coarse
        do_cmd(O_CLR, 0, 0, "R7");
        do_cmd(O_ADD, 10, 0, "R3");
        do_cmd(O_ADD, 2, 1, "R4");
        // full coarse vector: 63 targets
        for (int g = 0; g < 16; g++) do_cmd(O_ADD, g * 8, 0, "R6");
        do_cmd(O_INV, 127, 0, "R9 full");
        do_cmd(O_CLR, 0, 0, "R7");

        for (int k = 0; k < 400; k++) begin
            int r = $urandom % 16;
            int p = ($urandom % 2) ? int'($urandom % 32) : int'($urandom % 128);
            if (r < 8) do_cmd(O_ADD, p, ($urandom % 8) == 0, "R3 R4 R5 R6");
            else if (r < 10) do_cmd(O_OWN, p, 0, "R2");
            else if (r < 11) do_cmd(O_CLR, p, 0, "R7");
            else do_cmd(O_INV, p, 0, "R8");
        end
        finish_run();
    end

endmodule